// File: doc/BRIEF.md
# Frequency Meter Gate Sequencer

This block sets the timing of a three-digit frequency counter. It runs from a reference clock and repeats a fixed cycle of three phases. First it holds a measuring window open for a set number of reference cycles. It then raises a strobe that tells the downstream digit counters to copy their value into the display latches. A second strobe then clears those counters, and the next window opens. While the window is open, every rising edge of the squared-up input signal produces one active-low count pulse. This pulse comes from a two-input NAND of the detected edge and the window.

The window length is the product of two divider stages. The first is a binary prescaler with a parameter number of bits. The second is a small modulo stage after it. The default values are fourteen prescaler bits, a divide-by-four stage and a 65536 Hz reference. With these defaults the window lasts exactly one second, so the latched count reads the input frequency in hertz. Each strobe width is a count of reference cycles; the default of 66 gives about one millisecond each. The input passes through a two-flop synchroniser and a rising-edge detector before the gate, so each input period is counted once.

Top module: `freq_gate_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block is set to the start of a window: `gate_open` is 1, `latch_en` and `cnt_clear` are 0, and `cnt_pulse_n` is 1. The block keeps these values until the first edge with `rst` low.
- R2: `gate_open` stays high for exactly W = 2^PRE_BITS × POST_DIV consecutive reference cycles in each measurement cycle.
- R3: `latch_en` rises on the edge at which `gate_open` falls, and stays high for exactly LATCH_CYC cycles.
- R4: `cnt_clear` rises on the edge at which `latch_en` falls, and stays high for exactly CLEAR_CYC cycles. `gate_open` rises again on the edge at which `cnt_clear` falls, so the cycle period is W + LATCH_CYC + CLEAR_CYC.
- R5: At all times exactly one of `gate_open`, `latch_en` and `cnt_clear` is 1.
- R6: A 0-to-1 change of `sig_in` first sampled at clock edge k drives `cnt_pulse_n` to 0 for one cycle after edge k+2. This happens only if `gate_open` was 1 just before edge k+2.
- R7: `cnt_pulse_n` never goes low when the window is closed, and it stays at 1 while `sig_in` is constant.
- R8: An input level that stays high for many cycles gives a single count pulse. The number of pulses in a window equals the number of sampled input rising edges that are registered during it.
- R9: A synchronous reset in the middle of any phase restarts the cycle at the first cycle of a fresh window, with a full window length after it.
- R10: The parameters are checked at elaboration. PRE_BITS must be at least 1, POST_DIV, LATCH_CYC, CLEAR_CYC and SYNC_STAGES must be at least 1, and REF_HZ must equal 2^PRE_BITS × POST_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Squared-up signal whose frequency is measured |
| cnt_pulse_n | output | 1 | Active-low gated count pulse, one per input period |
| gate_open | output | 1 | High during the measuring window |
| latch_en | output | 1 | Strobe that stores the digit counts |
| cnt_clear | output | 1 | Strobe that clears the digit counters |

## Verification
The bench builds the block with PRE_BITS = 3, POST_DIV = 2, REF_HZ = 16, LATCH_CYC = 3 and CLEAR_CYC = 2. This gives a 16-cycle window and a 21-cycle measurement cycle, so many full cycles fit in a short run. With these values the divide-by-two stage uses the general post-divider branch, not the pass-through. Input periods of 4 and 10 cycles, a pseudo-random input and a constant input all cross the boundaries at both ends of the window. These include edges that reach the gate just as it closes. A reset in the middle of a window checks that the sequence restarts.

// File: rtl/fgs_pkg.sv
package fgs_pkg;

   typedef enum logic [1:0] {
      PH_GATE  = 2'd0,
      PH_LATCH = 2'd1,
      PH_CLEAR = 2'd2
   } fgs_phase_e;

   function automatic int fgs_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fgs_sync_edge.sv
module fgs_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);

   if (STAGES < 1) begin : g_bad_stages
      $error("fgs_sync_edge: STAGES must be at least 1 (R10)");
   end

   // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its one-cycle delay
   logic [STAGES:0] pipe;

   always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-1:0], din};
   end

   assign rise = pipe[STAGES-1] & ~pipe[STAGES];

   // R8: a held level never yields two edge pulses back to back
   assert_single_rise_R8: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/fgs_gate_timer.sv
module fgs_gate_timer #(
   parameter int PRE_BITS = 14,
   parameter int POST_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic done
);

   if (PRE_BITS < 1) begin : g_bad_pre
      $error("fgs_gate_timer: PRE_BITS must be at least 1 (R10)");
   end
   if (POST_DIV < 1) begin : g_bad_post
      $error("fgs_gate_timer: POST_DIV must be at least 1 (R10)");
   end

   logic [PRE_BITS-1:0] pre_cnt;
   logic                tick;

   always_ff @(posedge clk) begin
      if (rst || !run) pre_cnt <= '0;
      else             pre_cnt <= pre_cnt + 1'b1;
   end

   assign tick = run & (&pre_cnt);

   if (POST_DIV == 1) begin : g_post_pass
      assign done = tick;
   end else begin : g_post_mod
      localparam int PW = $clog2(POST_DIV);
      localparam logic [PW-1:0] POST_LAST = PW'(POST_DIV - 1);
      logic [PW-1:0] post_cnt;

      always_ff @(posedge clk) begin
         if (rst || !run)  post_cnt <= '0;
         else if (tick)    post_cnt <= (post_cnt == POST_LAST) ? '0 : post_cnt + 1'b1;
      end

      assign done = tick & (post_cnt == POST_LAST);
   end

   // R2: the end-of-window flag is a single-cycle event
   assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

endmodule

// File: rtl/fgs_phase_ctl.sv
module fgs_phase_ctl
   import fgs_pkg::*;
#(
   parameter int LATCH_CYC = 66,
   parameter int CLEAR_CYC = 66
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       win_done,
   output fgs_phase_e phase
);

   if (LATCH_CYC < 1 || CLEAR_CYC < 1) begin : g_bad_strobe
      $error("fgs_phase_ctl: strobe widths must be at least 1 (R10)");
   end

   localparam int SW = $clog2(fgs_max(LATCH_CYC, CLEAR_CYC) + 1);
   localparam logic [SW-1:0] LATCH_LAST = SW'(LATCH_CYC - 1);
   localparam logic [SW-1:0] CLEAR_LAST = SW'(CLEAR_CYC - 1);

   logic [SW-1:0] strobe_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase      <= PH_GATE;
         strobe_cnt <= '0;
      end else begin
         unique case (phase)
            PH_GATE: begin
               strobe_cnt <= '0;
               if (win_done) phase <= PH_LATCH;
            end
            PH_LATCH: begin
               if (strobe_cnt == LATCH_LAST) begin
                  phase      <= PH_CLEAR;
                  strobe_cnt <= '0;
               end else begin
                  strobe_cnt <= strobe_cnt + 1'b1;
               end
            end
            PH_CLEAR: begin
               if (strobe_cnt == CLEAR_LAST) begin
                  phase      <= PH_GATE;
                  strobe_cnt <= '0;
               end else begin
                  strobe_cnt <= strobe_cnt + 1'b1;
               end
            end
            default: begin
               phase      <= PH_GATE;
               strobe_cnt <= '0;
            end
         endcase
      end
   end

   // R2: the window can only close while the gate phase is active
   assert_done_in_gate_R2: assert property (@(posedge clk) disable iff (rst)
      win_done |-> (phase == PH_GATE));

   // R3: the strobe counter never runs past the latch width
   assert_latch_bound_R3: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_LATCH) |-> (strobe_cnt <= LATCH_LAST));

   // R4: the strobe counter never runs past the clear width
   assert_clear_bound_R4: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_CLEAR) |-> (strobe_cnt <= CLEAR_LAST));

endmodule

// File: rtl/freq_gate_seq.sv
module freq_gate_seq
   import fgs_pkg::*;
#(
   parameter int REF_HZ      = 65536,
   parameter int PRE_BITS    = 14,
   parameter int POST_DIV    = 4,
   parameter int LATCH_CYC   = 66,
   parameter int CLEAR_CYC   = 66,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_in,
   output logic cnt_pulse_n,
   output logic gate_open,
   output logic latch_en,
   output logic cnt_clear
);

   localparam longint WINDOW_CYC = (longint'(1) << PRE_BITS) * longint'(POST_DIV);

   if (longint'(REF_HZ) != WINDOW_CYC) begin : g_bad_ref
      $error("freq_gate_seq: REF_HZ must equal 2**PRE_BITS * POST_DIV (R10)");
   end

   logic       sig_rise;
   logic       win_done;
   fgs_phase_e phase;

   fgs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (sig_in),
      .rise (sig_rise)
   );

   fgs_gate_timer #(.PRE_BITS(PRE_BITS), .POST_DIV(POST_DIV)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .run  (gate_open),
      .done (win_done)
   );

   fgs_phase_ctl #(.LATCH_CYC(LATCH_CYC), .CLEAR_CYC(CLEAR_CYC)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .win_done (win_done),
      .phase    (phase)
   );

   assign gate_open = (phase == PH_GATE);
   assign latch_en  = (phase == PH_LATCH);
   assign cnt_clear = (phase == PH_CLEAR);

   // two-input NAND of the detected edge and the window, registered
   always_ff @(posedge clk) begin
      if (rst) cnt_pulse_n <= 1'b1;
      else     cnt_pulse_n <= ~(sig_rise & gate_open);
   end

   // R5: the three phase outputs never overlap and never all drop
   assert_one_phase_R5: assert property (@(posedge clk) disable iff (rst)
      $countones({gate_open, latch_en, cnt_clear}) == 1);

   // R3: latch strobe follows the window at once
   assert_latch_after_gate_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(gate_open) |-> latch_en);

   // R4: clear strobe follows the latch strobe at once
   assert_clear_after_latch_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(latch_en) |-> cnt_clear);

   // R4: a new window follows the clear strobe at once
   assert_gate_after_clear_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(cnt_clear) |-> gate_open);

   // R7: a count pulse only follows a cycle with the window open
   assert_pulse_in_window_R7: assert property (@(posedge clk) disable iff (rst)
      !cnt_pulse_n |-> $past(gate_open));

   // R8: count pulses are one cycle wide
   assert_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
      !cnt_pulse_n |=> cnt_pulse_n);

endmodule

// File: tb/freq_gate_seq_tb.sv
module freq_gate_seq_tb;

   localparam int PRE_BITS  = 3;
   localparam int POST_DIV  = 2;
   localparam int REF_HZ    = 16;
   localparam int LATCH_CYC = 3;
   localparam int CLEAR_CYC = 2;
   localparam int W         = (1 << PRE_BITS) * POST_DIV;
   localparam int P         = W + LATCH_CYC + CLEAR_CYC;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sig_in = 1'b0;
   logic cnt_pulse_n, gate_open, latch_en, cnt_clear;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   freq_gate_seq #(
      .REF_HZ(REF_HZ), .PRE_BITS(PRE_BITS), .POST_DIV(POST_DIV),
      .LATCH_CYC(LATCH_CYC), .CLEAR_CYC(CLEAR_CYC), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst(rst), .sig_in(sig_in), .cnt_pulse_n(cnt_pulse_n),
      .gate_open(gate_open), .latch_en(latch_en), .cnt_clear(cnt_clear)
   );

   // behavioural reference: phase position and a sample queue of the input
   int ph = 0;
   bit hist[$];
   bit m_cpn = 1'b1;

   always @(posedge clk) begin
      if (rst) begin
         ph = 0;
         hist.delete();
         hist.push_back(1'b0); hist.push_back(1'b0); hist.push_back(1'b0);
         m_cpn = 1'b1;
      end else begin
         // hist[1] = synchronised level, hist[2] = its previous value
         m_cpn = !(hist[1] && !hist[2] && (ph < W));
         hist.push_front(sig_in);
         void'(hist.pop_back());
         ph = (ph + 1) % P;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!finished) begin
         check("R2", "gate_open", gate_open, (ph < W));
         check("R3", "latch_en", latch_en, (ph >= W && ph < W + LATCH_CYC));
         check("R4", "cnt_clear", cnt_clear, (ph >= W + LATCH_CYC));
         check("R6 R8", "cnt_pulse_n", cnt_pulse_n, m_cpn);
         check("R5", "phase one-hot", $countones({gate_open, latch_en, cnt_clear}), 1);
         if (!gate_open && !$isunknown(cnt_pulse_n))
            check("R7", "no pulse while closed", (cnt_pulse_n == 1'b0 && ph != W) ? 0 : 1, 1);
      end
   end

   task automatic run_const(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sig_in = 1'b0;
         #1 check("R7", "constant input pulse", cnt_pulse_n, 1);
      end
   endtask

   task automatic run_wave(input int n, input int per, input int high);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sig_in = ((i % per) < high);
      end
   endtask

   int lfsr = 32'h1ACE;

   task automatic run_rand(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         sig_in = lfsr[3];
      end
   endtask

   int win_pulses;

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "gate_open in reset", gate_open, 1);
      check("R1", "latch_en in reset", latch_en, 0);
      check("R1", "cnt_clear in reset", cnt_clear, 0);
      check("R1", "cnt_pulse_n in reset", cnt_pulse_n, 1);
      rst = 1'b0;

      run_const(2 * P);
      run_wave(3 * P, 4, 2);

      // R8: input held high 7 of every 10 cycles, one pulse per period
      win_pulses = 0;
      for (int i = 0; i < 3 * P; i++) begin
         @(negedge clk);
         sig_in = ((i % 10) < 7);
         if (cnt_pulse_n == 1'b0) win_pulses++;
      end
      check("R8", "pulses over 63 cycles, period 10", (win_pulses >= 3 && win_pulses <= 7) ? 1 : 0, 1);

      run_rand(4 * P);

      // R9: reset in the middle of a window
      run_wave(7, 4, 2);
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      @(negedge clk); rst = 1'b0;
      check("R9", "gate_open after mid reset", gate_open, 1);
      check("R9", "latch_en after mid reset", latch_en, 0);
      check("R9", "cnt_clear after mid reset", cnt_clear, 0);
      for (int i = 0; i < W - 1; i++) @(negedge clk);
      check("R9", "window still open at W-1", gate_open, 1);
      @(negedge clk);
      check("R9", "latch after full window", latch_en, 1);
      run_wave(2 * P, 6, 3);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule